// File: doc/BRIEF.md
# UART receive path with line status register

This block is the receive half of a classic asynchronous serial port. It synchronises the serial input and samples it at sixteen times the bit rate. From that input it rebuilds characters of 5 to 8 data bits, with optional odd or even parity. Each finished character goes into a receive FIFO together with three error flags: parity, framing and break. The error bits of the status byte report the flags of the character at the FIFO head, so software can tell which character carried which error.

Software reads the status byte first and the data byte second. A strobe on the data side pops the head character. A strobe on the status side clears the sticky bits. Two flags from the transmit side enter the status byte unchanged. A mode input picks FIFO operation or single-character operation, and toggling it empties the FIFO.

Top module: `uart_rx_lsr`

## Requirements
- R1: After reset `lsr_out` is 0x60 and `rx_data` is 0x00. The bits of `lsr_out`, from bit 7 down to bit 0, are: FIFO-error, transmitter-empty, holding-empty, break, framing, parity, overrun, data-ready.
- R2: `baud_tick` pulses at 16 times the bit rate. A falling edge is accepted as a start bit only if the line is still low when it is sampled again half a bit later. A low pulse shorter than that stores nothing.
- R3: Data bits are received least significant bit first. `data_bits_sel` 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Data bits that are not received read as zero in `rx_data`.
- R4: When `parity_en`=1 a parity bit follows the data. `parity_even`=1 selects even parity and 0 selects odd parity. A mismatch flags a parity error on that character.
- R5: Only the first stop bit is checked. If it is sampled low, the character is stored with a framing error.
- R6: After a framing error, the low sample taken in the stop position counts as the start bit of the next character. The data bits of that next character are sampled one bit time after it, each one a bit time apart.
- R7: If the line is low for the start bit, all data bits, the parity bit and the stop bit, exactly one character 0x00 is stored with the break flag set. No further character is received until the line goes high and a new start bit arrives.
- R8: Bits 4..2 show the break, framing and parity flags of the character at the FIFO head, and read 0 when the FIFO is empty. A status read hides them for the current head until the head changes.
- R9: In FIFO mode, bit 7 is set when a character with any error enters the FIFO. A status read clears bit 7 only if no character with an error remains in the FIFO.
- R10: The FIFO holds 16 characters in order. Bit 0 is 1 whenever the FIFO is not empty, and `rd_data_stb` removes the head character.
- R11: A character that completes while the FIFO is full is discarded and sets bit 1. A status read clears bit 1.
- R12: With `fifo_mode`=0 only one character is held, and a second character causes an overrun. A newly loaded character shows its own framing flag. Any change of `fifo_mode` empties the FIFO.
- R13: Bit 5 equals `thr_empty`. Bit 6 equals `thr_empty` AND `tsr_idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Serial input line, idle high |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| data_bits_sel | input | 2 | Data width: 0..3 selects 5..8 bits |
| parity_en | input | 1 | Parity bit present |
| parity_even | input | 1 | 1 selects even parity, 0 selects odd |
| fifo_mode | input | 1 | 1 for 16-entry FIFO, 0 for single holding register |
| rd_data_stb | input | 1 | Pops the head character |
| rd_status_stb | input | 1 | Status read; clears the sticky bits |
| thr_empty | input | 1 | Transmit holding register or FIFO empty |
| tsr_idle | input | 1 | Transmit shift register empty |
| rx_data | output | 8 | Head character, registered; 0 when empty |
| lsr_out | output | 8 | Line status byte, registered |

## Verification
The assertions check on every cycle that:
- the FIFO count never exceeds its depth;
- a push into a full FIFO leaves the count unchanged;
- the number of errored entries never exceeds the count;
- transmitter-empty implies holding-empty;
- an overrun event always sets the overrun flag;
- the FIFO-error bit stays set while errored characters remain;
- data-ready falls after the FIFO empties;
- a character complete pulse lasts one cycle;
- no character is produced while waiting out a break;
- 5-bit characters have zero high bits.

Only the bench's scenarios can show the rest:
- bit timing;
- parity values across all formats;
- resynchronisation after a framing error;
- head-ordered error reporting;
- the single break character;
- the effect of the mode switch.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic [7:0] data;
    logic       pe;
    logic       fe;
    logic       bi;
  } rx_char_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_BRK
  } rx_state_e;

  localparam int LSR_DR   = 0;
  localparam int LSR_OE   = 1;
  localparam int LSR_PE   = 2;
  localparam int LSR_FE   = 3;
  localparam int LSR_BI   = 4;
  localparam int LSR_THRE = 5;
  localparam int LSR_TEMT = 6;
  localparam int LSR_FERR = 7;

  localparam logic [7:0] LSR_RESET = 8'h60;

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_in,
  input  logic       baud_tick,
  input  logic [1:0] data_bits_sel,
  input  logic       parity_en,
  input  logic       parity_even,
  output logic       char_valid,
  output rx_char_t   char_out
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] HALF_C = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_C = CW'(OSR - 1);

  logic [SYNC-1:0] sync_q;
  logic            rx_s;
  rx_state_e       state;
  logic [CW-1:0]   cnt;
  logic [2:0]      bit_idx;
  logic [2:0]      last_idx;
  logic [7:0]      shreg;
  logic            par_bit;
  logic            all_zero;
  logic            perr;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC-2:0], rx_in};
  end

  assign rx_s     = sync_q[SYNC-1];
  assign last_idx = 3'd4 + {1'b0, data_bits_sel};

  always_comb perr = parity_en & ((^shreg) ^ par_bit ^ !parity_even);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= RX_IDLE;
      cnt        <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      par_bit    <= 1'b0;
      all_zero   <= 1'b1;
      char_valid <= 1'b0;
      char_out   <= '0;
    end else begin
      char_valid <= 1'b0;
      if (baud_tick) begin
        case (state)
          RX_IDLE: begin
            if (!rx_s) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == HALF_C) begin
              cnt <= '0;
              if (!rx_s) begin
                state    <= RX_DATA;
                bit_idx  <= '0;
                shreg    <= '0;
                par_bit  <= 1'b0;
                all_zero <= 1'b1;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == LAST_C) begin
              cnt            <= '0;
              shreg[bit_idx] <= rx_s;
              if (rx_s) all_zero <= 1'b0;
              if (bit_idx == last_idx) state <= parity_en ? RX_PAR : RX_STOP;
              else                     bit_idx <= bit_idx + 3'd1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (cnt == LAST_C) begin
              cnt     <= '0;
              par_bit <= rx_s;
              if (rx_s) all_zero <= 1'b0;
              state   <= RX_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == LAST_C) begin
              cnt        <= '0;
              char_valid <= 1'b1;
              if (rx_s) begin
                char_out.data <= shreg;
                char_out.pe   <= perr;
                char_out.fe   <= 1'b0;
                char_out.bi   <= 1'b0;
                state         <= RX_IDLE;
              end else if (all_zero) begin
                char_out <= '0;
                char_out.bi <= 1'b1;
                state <= RX_BRK;
              end else begin
                char_out.data <= shreg;
                char_out.pe   <= perr;
                char_out.fe   <= 1'b1;
                char_out.bi   <= 1'b0;
                state         <= RX_DATA;
                bit_idx       <= '0;
                shreg         <= '0;
                par_bit       <= 1'b0;
                all_zero      <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_BRK: begin
            if (rx_s) state <= RX_IDLE;
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    char_valid |=> !char_valid);

  // R7
  break_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == RX_BRK) |=> !char_valid);

  // R3
  narrow_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (char_valid && data_bits_sel == 2'd0) |-> (char_out.data[7:5] == 3'b000));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic               one_deep,
  input  logic               push,
  input  rx_char_t           push_word,
  input  logic               pop,
  output rx_char_t           head,
  output logic               full,
  output logic               empty,
  output logic [$clog2(DEPTH):0] err_cnt
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_C = (AW + 1)'(DEPTH);

  rx_char_t      mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;
  logic [AW:0]   count;
  logic          do_push;
  logic          do_pop;
  logic          push_e;
  logic          pop_e;

  assign empty   = (count == '0);
  assign full    = one_deep ? !empty : (count == DEPTH_C);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign push_e  = do_push && (push_word.pe || push_word.fe || push_word.bi);
  assign pop_e   = do_pop && (head.pe || head.fe || head.bi);
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      case ({push_e, pop_e})
        2'b10:   err_cnt <= err_cnt + 1'b1;
        2'b01:   err_cnt <= err_cnt - 1'b1;
        default: err_cnt <= err_cnt;
      endcase
    end
  end

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH_C);

  // R11
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> $stable(count));

  // R9
  err_bound_chk: assert property (@(posedge clk) disable iff (rst)
    err_cnt <= count);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fifo_mode,
  input  logic                   flush,
  input  logic                   rd_status_stb,
  input  logic                   head_change,
  input  logic                   push_err,
  input  logic                   ovr_evt,
  input  rx_char_t               head,
  input  logic                   empty,
  input  logic [$clog2(DEPTH):0] err_cnt,
  input  logic                   thr_empty,
  input  logic                   tsr_idle,
  output logic [7:0]             lsr_out,
  output logic [7:0]             rx_data
);

  logic       err_mask;
  logic       fifo_err;
  logic       ovr;
  logic [7:0] lsr_d;
  logic       show;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      err_mask <= 1'b0;
      fifo_err <= 1'b0;
    end else begin
      if (head_change)        err_mask <= 1'b0;
      else if (rd_status_stb) err_mask <= 1'b1;
      if (fifo_mode && push_err)             fifo_err <= 1'b1;
      else if (rd_status_stb && err_cnt == '0) fifo_err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                ovr <= 1'b0;
    else if (ovr_evt)       ovr <= 1'b1;
    else if (rd_status_stb) ovr <= 1'b0;
  end

  assign show = !empty && !err_mask;

  always_comb begin
    lsr_d           = '0;
    lsr_d[LSR_DR]   = !empty;
    lsr_d[LSR_OE]   = ovr;
    lsr_d[LSR_PE]   = show && head.pe;
    lsr_d[LSR_FE]   = show && head.fe;
    lsr_d[LSR_BI]   = show && head.bi;
    lsr_d[LSR_THRE] = thr_empty;
    lsr_d[LSR_TEMT] = thr_empty && tsr_idle;
    lsr_d[LSR_FERR] = fifo_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lsr_out <= LSR_RESET;
      rx_data <= '0;
    end else begin
      lsr_out <= lsr_d;
      rx_data <= empty ? 8'h00 : head.data;
    end
  end

  // R13
  temt_thre_chk: assert property (@(posedge clk) disable iff (rst)
    lsr_out[LSR_TEMT] |-> lsr_out[LSR_THRE]);

  // R11
  ovr_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_evt |=> ovr);

  // R9
  ferr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_err && err_cnt != '0 && !flush) |=> fifo_err);

  // R10
  dr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    empty |=> !lsr_out[LSR_DR]);

endmodule

// File: rtl/uart_rx_lsr.sv
module uart_rx_lsr
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OSR   = 16,
  parameter int SYNC  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_in,
  input  logic       baud_tick,
  input  logic [1:0] data_bits_sel,
  input  logic       parity_en,
  input  logic       parity_even,
  input  logic       fifo_mode,
  input  logic       rd_data_stb,
  input  logic       rd_status_stb,
  input  logic       thr_empty,
  input  logic       tsr_idle,
  output logic [7:0] rx_data,
  output logic [7:0] lsr_out
);

  localparam int AW = $clog2(DEPTH);

  logic          char_valid;
  rx_char_t      char_word;
  rx_char_t      head;
  logic          full;
  logic          empty;
  logic [AW:0]   err_cnt;
  logic          mode_q;
  logic          flush;
  logic          pop_eff;
  logic          push_ok;
  logic          head_change;
  logic          push_err;
  logic          ovr_evt;

  always_ff @(posedge clk) begin
    mode_q <= fifo_mode;
  end

  assign flush       = !rst && (fifo_mode != mode_q);
  assign pop_eff     = rd_data_stb && !empty;
  assign push_ok     = char_valid && !full;
  assign head_change = pop_eff || (push_ok && empty) || flush;
  assign push_err    = push_ok && (char_word.pe || char_word.fe || char_word.bi);
  assign ovr_evt     = char_valid && full;

  uart_rx_sampler #(.OSR(OSR), .SYNC(SYNC)) u_sampler (
    .clk           (clk),
    .rst           (rst),
    .rx_in         (rx_in),
    .baud_tick     (baud_tick),
    .data_bits_sel (data_bits_sel),
    .parity_en     (parity_en),
    .parity_even   (parity_even),
    .char_valid    (char_valid),
    .char_out      (char_word)
  );

  uart_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .one_deep  (!fifo_mode),
    .push      (char_valid),
    .push_word (char_word),
    .pop       (rd_data_stb),
    .head      (head),
    .full      (full),
    .empty     (empty),
    .err_cnt   (err_cnt)
  );

  uart_rx_status #(.DEPTH(DEPTH)) u_status (
    .clk           (clk),
    .rst           (rst),
    .fifo_mode     (fifo_mode),
    .flush         (flush),
    .rd_status_stb (rd_status_stb),
    .head_change   (head_change),
    .push_err      (push_err),
    .ovr_evt       (ovr_evt),
    .head          (head),
    .empty         (empty),
    .err_cnt       (err_cnt),
    .thr_empty     (thr_empty),
    .tsr_idle      (tsr_idle),
    .lsr_out       (lsr_out),
    .rx_data       (rx_data)
  );

endmodule

// File: tb/sim_uart_rx_lsr.sv
module sim_uart_rx_lsr;

  localparam int BITCLK = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_in = 1'b1;
  logic       baud_tick = 1'b0;
  logic [1:0] data_bits_sel = 2'd3;
  logic       parity_en = 1'b0;
  logic       parity_even = 1'b0;
  logic       fifo_mode = 1'b1;
  logic       rd_data_stb = 1'b0;
  logic       rd_status_stb = 1'b0;
  logic       thr_empty = 1'b1;
  logic       tsr_idle = 1'b1;
  logic [7:0] rx_data;
  logic [7:0] lsr_out;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  uart_rx_lsr u0 (
    .clk(clk), .rst(rst), .rx_in(rx_in), .baud_tick(baud_tick),
    .data_bits_sel(data_bits_sel), .parity_en(parity_en), .parity_even(parity_even),
    .fifo_mode(fifo_mode), .rd_data_stb(rd_data_stb), .rd_status_stb(rd_status_stb),
    .thr_empty(thr_empty), .tsr_idle(tsr_idle), .rx_data(rx_data), .lsr_out(lsr_out)
  );

  always #10 clk = ~clk;
  always @(negedge clk) baud_tick <= ~baud_tick;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: actual %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bit_out(input logic v);
    rx_in = v;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic idle_bits(input int n);
    rx_in = 1'b1;
    repeat (n * BITCLK) @(negedge clk);
  endtask

  function automatic logic [7:0] wmask(input int nb);
    return 8'((1 << nb) - 1);
  endfunction

  function automatic logic par_of(input logic [7:0] d, input int nb, input logic even);
    logic p;
    p = ^(d & wmask(nb));
    return even ? p : ~p;
  endfunction

  // start, data LSB first, optional parity, one stop bit (no trailing idle)
  task automatic send(input logic [7:0] d, input logic flip, input logic stopv);
    int nb;
    nb = 5 + int'(data_bits_sel);
    bit_out(1'b0);
    for (int i = 0; i < nb; i++) bit_out(d[i]);
    if (parity_en) bit_out(par_of(d, nb, parity_even) ^ flip);
    bit_out(stopv);
  endtask

  task automatic rd_status(output logic [7:0] v);
    v = lsr_out;
    rd_status_stb = 1'b1;
    @(negedge clk);
    rd_status_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pop(output logic [7:0] d);
    d = rx_data;
    rd_data_stb = 1'b1;
    @(negedge clk);
    rd_data_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] d;
    logic [7:0] m;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 reset lsr", lsr_out, 8'h60);
    chk("R1 reset data", rx_data, 8'h00);

    // R2 short low glitch stores nothing
    rx_in = 1'b0;
    repeat (6) @(negedge clk);
    idle_bits(2);
    chk("R2 glitch ignored", lsr_out, 8'h60);

    // R3 R4 format sweep: 4 widths x 3 parity modes x 8 values
    for (int sel = 0; sel < 4; sel++) begin
      for (int pm = 0; pm < 3; pm++) begin
        data_bits_sel = 2'(sel);
        parity_en     = (pm != 0);
        parity_even   = (pm == 2);
        m = wmask(5 + sel);
        for (int k = 0; k < 8; k++) begin
          case (k)
            0: v = 8'h00; 1: v = 8'hFF; 2: v = 8'hA5; 3: v = 8'h5A;
            4: v = 8'h01; 5: v = 8'h80; 6: v = 8'h3C; default: v = 8'(k * 37 + sel);
          endcase
          send(v, 1'b0, 1'b1);
          idle_bits(1);
          chk("R3 R4 good char lsr", lsr_out, 8'h61);
          chk("R3 data LSB first, high bits zero", rx_data, v & m);
          pop(d);
          chk("R10 empty after pop", lsr_out, 8'h60);
        end
        if (pm != 0) begin
          v = 8'h96;
          send(v, 1'b1, 1'b1);
          idle_bits(1);
          chk("R4 parity error lsr", lsr_out, 8'hE5);
          chk("R4 parity error data", rx_data, v & m);
          rd_status(d);
          chk("R8 PE hidden after status read", lsr_out, 8'hE1);
          pop(d);
          chk("R9 FIFO-error sticky after pop", lsr_out, 8'hE0);
          rd_status(d);
          chk("R9 FIFO-error cleared", lsr_out, 8'h60);
        end
      end
    end

    // R5 R6 framing error then resync: 8 bits, no parity
    data_bits_sel = 2'd3; parity_en = 1'b0; parity_even = 1'b0;
    send(8'h3C, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) bit_out(8'hC3 >> i);
    bit_out(1'b1);
    idle_bits(1);
    chk("R5 framing error lsr", lsr_out, 8'hE9);
    chk("R5 framing char data", rx_data, 8'h3C);
    rd_status(d);
    pop(d);
    chk("R6 resync char lsr", lsr_out, 8'hE1);
    chk("R6 resync char data", rx_data, 8'hC3);
    pop(d);
    chk("R9 sticky until read", lsr_out, 8'hE0);
    rd_status(d);
    chk("R9 cleared by read", lsr_out, 8'h60);

    // R8 head reporting, even parity
    parity_en = 1'b1; parity_even = 1'b1;
    send(8'h11, 1'b0, 1'b1); idle_bits(1);
    send(8'h22, 1'b1, 1'b1); idle_bits(1);
    send(8'h33, 1'b0, 1'b1); idle_bits(1);
    chk("R8 head good, newer error", lsr_out, 8'hE1);
    pop(d);
    chk("R8 first pop data", d, 8'h11);
    chk("R8 errored head shows PE", lsr_out, 8'hE5);
    rd_status(d);
    chk("R8 status read value", d, 8'hE5);
    chk("R8 PE hidden for this head", lsr_out, 8'hE1);
    pop(d);
    chk("R8 second pop data", d, 8'h22);
    chk("R8 third head clean", lsr_out, 8'hE1);
    pop(d);
    chk("R8 third pop data", d, 8'h33);
    rd_status(d);
    chk("R9 clean after read", lsr_out, 8'h60);

    // R7 break
    parity_en = 1'b0;
    rx_in = 1'b0;
    repeat (30 * BITCLK) @(negedge clk);
    idle_bits(2);
    chk("R7 break lsr", lsr_out, 8'hF1);
    chk("R7 break data zero", rx_data, 8'h00);
    pop(d);
    chk("R7 single break char", lsr_out, 8'hE0);
    rd_status(d);
    send(8'h5A, 1'b0, 1'b1); idle_bits(1);
    chk("R7 char after break lsr", lsr_out, 8'h61);
    chk("R7 char after break data", rx_data, 8'h5A);
    pop(d);

    // R10 R11 fill and overrun
    for (int i = 0; i < 17; i++) begin
      send(8'(i * 13 + 7), 1'b0, 1'b1);
      idle_bits(1);
      if (i == 15) chk("R10 full no overrun", lsr_out, 8'h61);
    end
    chk("R11 overrun set", lsr_out, 8'h63);
    rd_status(d);
    chk("R11 overrun cleared by read", lsr_out, 8'h61);
    for (int i = 0; i < 16; i++) begin
      pop(d);
      chk("R10 FIFO order", d, 8'(i * 13 + 7));
    end
    chk("R11 dropped char absent", lsr_out, 8'h60);

    // R12 single holding mode
    fifo_mode = 1'b0;
    repeat (4) @(negedge clk);
    send(8'h81, 1'b0, 1'b1); idle_bits(1);
    send(8'h42, 1'b0, 1'b1); idle_bits(1);
    chk("R12 second char overruns", lsr_out, 8'h63);
    chk("R12 first char kept", rx_data, 8'h81);
    rd_status(d);
    pop(d);
    chk("R12 empty", lsr_out, 8'h60);
    send(8'h0F, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) bit_out(1'b1);
    bit_out(1'b1);
    idle_bits(1);
    chk("R12 framing plus overrun", lsr_out, 8'h6B);
    rd_status(d);
    chk("R12 FE and OE cleared by read", lsr_out, 8'h61);
    pop(d);
    send(8'h99, 1'b0, 1'b1); idle_bits(1);
    chk("R12 new load clean FE", lsr_out, 8'h61);
    chk("R12 new load data", rx_data, 8'h99);
    fifo_mode = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 mode change flushes", lsr_out, 8'h60);

    // R13 transmit flags
    for (int t = 0; t < 4; t++) begin
      thr_empty = t[0];
      tsr_idle  = t[1];
      repeat (3) @(negedge clk);
      chk("R13 THRE/TEMT", lsr_out, {1'b0, t[0] & t[1], t[0], 5'b0});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog (R10 flow): actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule